// File: doc/BRIEF.md
# Three-Level Interrupt Priority Arbiter

This block merges the interrupt sources of a serial controller into one active-low request line. Sources come from three sections, ranked by fixed priority: receiver (highest), transmitter, and modem-status (lowest). Each section presents an 8-bit status byte. A per-section mask selects which status bits may raise a request. A section whose masked status is nonzero is pending. Each section has a level state machine with three states: none, requested and acknowledged.

When the processor runs an acknowledge cycle, the block picks the highest-priority requested level that is not shadowed by a higher acknowledged level. During that same cycle it drives the 8-bit vector programmed for that level, and the level then moves to acknowledged. A level in service keeps lower levels from raising or winning the line. A higher level can still interrupt a lower level in service. Software clears the status bits of a section, and the level then drops back to none.

The vector response has no back-pressure. `vec_valid` and `vec_data` are valid only while `iack` is high, and they must be sampled in that cycle. All other pins are plain level signals. A simple register-write port loads the three masks and the three vectors.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, `irq_n` is 1, `lvl_state` is all zero, `vec_valid` is 0, and all masks and vectors are zero.
- R2: `lvl_state` holds 2 bits per level: bits [1:0] receiver, [3:2] transmitter, [5:4] modem-status. The encodings are 0 = none, 1 = requested, 2 = acknowledged, and the value 3 never appears.
- R3: A level is pending only when its status AND its mask AND its implemented bits is nonzero. Implemented bits are: receiver 7,6,4,3,2,1; transmitter 7,6,2,1; modem-status 7,6,5. Any other status or mask bit is ignored.
- R4: A level in the none state that is pending moves to requested at the next clock edge.
- R5: `irq_n` is 0 exactly when some level is requested and no higher-priority level is acknowledged.
- R6: While `iack` is 1, `vec_valid` is 1 and `vec_data` carries the vector of the highest eligible requested level. That level becomes acknowledged at the clock edge. At most one level is granted per cycle.
- R7: An `iack` with no eligible level gives `vec_valid` 0 and `vec_data` 0, and it leaves all states unchanged.
- R8: While a level is acknowledged, a requested lower level neither drives `irq_n` low nor wins an acknowledge.
- R9: A requested level of higher priority than an acknowledged level drives `irq_n` low and wins the next acknowledge.
- R10: A level that is no longer pending returns to none at the next clock edge, whether it was requested or acknowledged.
- R11: With `cfg_we` set, address 0/1/2 loads the receiver/transmitter/modem-status mask and address 3/4/5 loads the matching vector. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| rx_stat | input | 8 | Receiver status byte |
| tx_stat | input | 8 | Transmitter status byte |
| si_stat | input | 8 | Modem-status status byte |
| iack | input | 1 | Interrupt acknowledge cycle |
| irq_n | output | 1 | Active-low interrupt request |
| vec_valid | output | 1 | Vector valid during acknowledge |
| vec_data | output | 8 | Acknowledged vector |
| lvl_state | output | 6 | Per-level state, 2 bits per level |

## Verification
The hardest situations to set up are nesting cases: a lower level held off by a level in service, and a higher level breaking into a lower level in service. Directed stimulus reaches them in order. The bench raises all three sections together, acknowledges the receiver and tries to acknowledge again while the transmitter waits. In a separate step it acknowledges the modem-status level first and only then raises the receiver. Masks with only unimplemented bits set show that those positions are ignored.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_LVL = 3;
  localparam int STAT_W  = 8;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_REQ  = 2'd1,
    LVL_ACK  = 2'd2
  } lvl_state_e;

  // implemented source positions per level (0 = receiver, highest)
  function automatic logic [STAT_W-1:0] impl_bits(input int lvl);
    case (lvl)
      0:       impl_bits = 8'hDE;
      1:       impl_bits = 8'hC6;
      default: impl_bits = 8'hE0;
    endcase
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_LVL-1:0][STAT_W-1:0]      mask_o,
  output logic [NUM_LVL-1:0][DATA_W-1:0]      vec_o
);
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(NUM_LVL + i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_o[i] <= '0;
        vec_o[i]  <= '0;
      end else if (we) begin
        if (addr == MASK_ADDR) mask_o[i] <= wdata[STAT_W-1:0];
        if (addr == VEC_ADDR)  vec_o[i]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend,
  input  logic       grant,
  output lvl_state_e state
);
  lvl_state_e nxt;

  always_comb begin
    nxt = state;
    if (!pend) begin
      nxt = LVL_NONE;
    end else begin
      case (state)
        LVL_NONE: nxt = LVL_REQ;
        LVL_REQ:  nxt = grant ? LVL_ACK : LVL_REQ;
        LVL_ACK:  nxt = LVL_ACK;
        default:  nxt = LVL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LVL_NONE;
    else        state <= nxt;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_LVL-1:0][1:0]        st,
  input  logic [NUM_LVL-1:0][DATA_W-1:0] vecs,
  input  logic                           iack,
  output logic [NUM_LVL-1:0]             grant,
  output logic                           irq_n,
  output logic                           vec_valid,
  output logic [DATA_W-1:0]              vec_data
);
  logic              found;
  logic              blocked;
  logic [DATA_W-1:0] win_vec;

  // walk from highest priority (index 0) downward
  always_comb begin
    found   = 1'b0;
    blocked = 1'b0;
    grant   = '0;
    win_vec = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (!found && !blocked && st[i] == LVL_REQ) begin
        found    = 1'b1;
        grant[i] = iack;
        win_vec  = vecs[i];
      end
      if (st[i] == LVL_ACK) blocked = 1'b1;
    end
  end

  assign irq_n     = ~found;
  assign vec_valid = iack & found;
  assign vec_data  = vec_valid ? win_vec : '0;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [STAT_W-1:0]    rx_stat,
  input  logic [STAT_W-1:0]    tx_stat,
  input  logic [STAT_W-1:0]    si_stat,
  input  logic                 iack,
  output logic                 irq_n,
  output logic                 vec_valid,
  output logic [DATA_W-1:0]    vec_data,
  output logic [2*NUM_LVL-1:0] lvl_state
);
  logic [NUM_LVL-1:0][STAT_W-1:0] stat;
  logic [NUM_LVL-1:0][STAT_W-1:0] mask;
  logic [NUM_LVL-1:0][DATA_W-1:0] vecs;
  logic [NUM_LVL-1:0][1:0]        st;
  logic [NUM_LVL-1:0]             pend;
  logic [NUM_LVL-1:0]             grant;

  assign stat = {si_stat, tx_stat, rx_stat};

  irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .mask_o(mask), .vec_o(vecs)
  );

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    lvl_state_e s;
    assign pend[i] = |(stat[i] & mask[i] & impl_bits(i));
    irq_level_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .pend(pend[i]), .grant(grant[i]), .state(s)
    );
    assign st[i] = s;
    assign lvl_state[2*i +: 2] = s;
  end

  irq_prio_pick #(.DATA_W(DATA_W)) u_pick (
    .st(st), .vecs(vecs), .iack(iack), .grant(grant),
    .irq_n(irq_n), .vec_valid(vec_valid), .vec_data(vec_data)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iack,
  input logic       irq_n,
  input logic       vec_valid,
  input logic [7:0] rx_stat,
  input logic [7:0] tx_stat,
  input logic [7:0] si_stat,
  input logic [5:0] lvl_state
);
  logic [2:0] is_req;
  logic [2:0] is_ack;
  for (genvar i = 0; i < 3; i++) begin : g_dec
    assign is_req[i] = lvl_state[2*i +: 2] == 2'd1;
    assign is_ack[i] = lvl_state[2*i +: 2] == 2'd2;

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_state[2*i +: 2] != 2'd3);

    // R6
    ack_needs_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_ack[i] && !iack) |=> !is_ack[i]);
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(is_ack & ~$past(is_ack)) <= 1);

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (is_req != 3'b000));

  // R6
  valid_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !irq_n);

  // R10
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stat == 8'h00) |=> lvl_state[1:0] == 2'd0);
  // R10
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stat == 8'h00) |=> lvl_state[3:2] == 2'd0);
  // R10
  si_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_stat == 8'h00) |=> lvl_state[5:4] == 2'd0);
endmodule

bind irq_prio_arb irq_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iack(iack), .irq_n(irq_n),
  .vec_valid(vec_valid), .rx_stat(rx_stat), .tx_stat(tx_stat),
  .si_stat(si_stat), .lvl_state(lvl_state)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] rx_stat = '0, tx_stat = '0, si_stat = '0;
  logic       iack = 1'b0;
  logic       irq_n, vec_valid;
  logic [7:0] vec_data;
  logic [5:0] lvl_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_arb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_stat(rx_stat), .tx_stat(tx_stat),
    .si_stat(si_stat), .iack(iack), .irq_n(irq_n), .vec_valid(vec_valid),
    .vec_data(vec_data), .lvl_state(lvl_state)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // drive iack for one cycle, check the combinational response, then step
  task automatic ack(input string tag, input logic v, input logic [7:0] d);
    iack = 1'b1;
    #1;
    chk({tag, " vec_valid"}, {7'd0, vec_valid}, {7'd0, v});
    chk({tag, " vec_data"}, vec_data, d);
    tick();
    iack = 1'b0;
  endtask

  task automatic clear_all();
    rx_stat = '0; tx_stat = '0; si_stat = '0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 lvl_state", {2'd0, lvl_state}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rx_stat = 8'hFF; tx_stat = 8'hFF; si_stat = 8'hFF;
    tick();
    chk("R1 zero masks block", {2'd0, lvl_state}, 8'h00);
    clear_all();
  endtask

  task automatic t_mask();
    wr(3'd0, 8'h21); wr(3'd1, 8'h39); wr(3'd2, 8'h1F);
    rx_stat = 8'hFF; tx_stat = 8'hFF; si_stat = 8'hFF;
    tick();
    chk("R3 unimplemented bits ignored", {2'd0, lvl_state}, 8'h00);
    chk("R3 irq_n idle", {7'd0, irq_n}, 8'h01);
    clear_all();
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    si_stat = 8'h1F;
    tick();
    chk("R3 si low bits ignored", {2'd0, lvl_state}, 8'h00);
    rx_stat = 8'h02; si_stat = 8'h00;
    tick();
    chk("R3 rx bit1 pending", {2'd0, lvl_state}, 8'h01);
    clear_all();
  endtask

  task automatic t_vectors();
    wr(3'd3, 8'h40); wr(3'd4, 8'h51); wr(3'd5, 8'h62);
    wr(3'd6, 8'hAA); wr(3'd7, 8'hBB);
  endtask

  task automatic t_basic();
    tx_stat = 8'h04;
    #1;
    chk("R4 not yet requested", {2'd0, lvl_state}, 8'h00);
    tick();
    chk("R4 tx requested", {2'd0, lvl_state}, 8'h04);
    chk("R5 irq low", {7'd0, irq_n}, 8'h00);
    ack("R6 tx ack", 1'b1, 8'h51);
    chk("R6 tx acknowledged", {2'd0, lvl_state}, 8'h08);
    chk("R5 irq high in service", {7'd0, irq_n}, 8'h01);
    tx_stat = 8'h00;
    tick();
    chk("R10 tx back to none", {2'd0, lvl_state}, 8'h00);
  endtask

  task automatic t_nesting();
    rx_stat = 8'h80; tx_stat = 8'h40; si_stat = 8'h20;
    tick();
    chk("R4 all requested", {2'd0, lvl_state}, 8'h15);
    ack("R6 rx wins", 1'b1, 8'h40);
    chk("R6 rx acknowledged", {2'd0, lvl_state}, 8'h16);
    chk("R8 irq held off", {7'd0, irq_n}, 8'h01);
    ack("R7 no eligible", 1'b0, 8'h00);
    chk("R7 states unchanged", {2'd0, lvl_state}, 8'h16);
    rx_stat = 8'h00;
    tick();
    chk("R10 rx released", {2'd0, lvl_state}, 8'h14);
    chk("R5 tx raises irq", {7'd0, irq_n}, 8'h00);
    ack("R11 addr6/7 no effect on tx vector", 1'b1, 8'h51);
    chk("R8 si still waits", {2'd0, lvl_state}, 8'h18);
    clear_all();
  endtask

  task automatic t_preempt();
    si_stat = 8'h80;
    tick();
    ack("R6 si ack", 1'b1, 8'h62);
    chk("R6 si acknowledged", {2'd0, lvl_state}, 8'h20);
    rx_stat = 8'h10;
    tick();
    chk("R9 rx requested", {2'd0, lvl_state}, 8'h21);
    chk("R9 irq low", {7'd0, irq_n}, 8'h00);
    ack("R9 rx preempts", 1'b1, 8'h40);
    chk("R9 both in service", {2'd0, lvl_state}, 8'h22);
    clear_all();
    chk("R10 all none", {2'd0, lvl_state}, 8'h00);
    wr(3'd3, 8'h99);
    rx_stat = 8'h08;
    tick();
    ack("R11 rx vector reload", 1'b1, 8'h99);
    clear_all();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask();
    t_vectors();
    t_basic();
    t_nesting();
    t_preempt();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule